// File: doc/BRIEF.md
# Inter-Core Interrupt and Mailbox Hub

This block lets any core of a small multiprocessor interrupt any core, itself included, and hand over a 16-bit message with that interrupt. Every core owns a pair of 32-bit registers inside one shared register window: a command register and a mailbox register. Writing the command register with the send bit set deposits a message in the mailbox of the chosen target core and raises the target's interrupt line. The target core answers by writing the acknowledge bit to its own command register. That drops its line and keeps the message fields readable.

The register port is a plain 32-bit bus: address, write strobe, write data and a combinational read data path. There is one level interrupt output per core. There is no queue behind a mailbox. A newer message replaces an older one. The number of cores is a parameter. It defaults to 1 and is meant for values from 1 to 4.

Top module: `xcore_irq_hub`

## Requirements
- R1: Address bits 1:0 are ignored. Bit 2 picks the command register (0) or the mailbox register (1). Bits from bit 3 upward give the core index, so each core occupies 8 bytes.
- R2: A write to a command register stores all 32 bits, and a read of that command register returns the stored value.
- R3: A command write with bit 30 (send) set overwrites the mailbox of the core named in bits 29:16. The new mailbox has bit 31 = 0, bit 30 = 1 (pending), bits 29:16 = the writer's core index and bits 15:0 = the written bits 15:0. It also raises the target's interrupt line.
- R4: A command write with bit 31 (acknowledge) set clears the pending bit of the writer's own mailbox and lowers its interrupt line. Mailbox bits 29:16 and 15:0 keep their values.
- R5: Within one write, send is applied before acknowledge. A core that sends to itself with both bits set ends with a refreshed mailbox whose pending bit is 0, and its line is low.
- R6: Writes to a mailbox register change no register and no interrupt line.
- R7: A send whose target index is not below the core count changes no mailbox and raises no line.
- R8: An access whose core index is not below the core count reads as zero, and a write to it has no effect.
- R9: Reset clears every command and mailbox register and lowers every interrupt line.
- R10: A write takes effect at the clock edge of its cycle. A read in the next cycle returns the new value, and the interrupt lines change at that same edge.
- R11: A second send to a core whose mailbox is still pending replaces the sender and payload fields, and the line stays high.
- R12: Each interrupt output equals the pending bit of that core's mailbox in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address into the register window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | NUM_CORES | Level interrupt line per core |

## Verification
The hardest case to reach is one write that both sends and acknowledges, with the writer as the target. In that cycle the same mailbox is first filled and then cleared, and the result depends on the order of the two actions. The directed sequence builds this case on purpose: it first makes core 0 pending, then has core 0 write a command with both bits set and its own index as target. Long random phases follow. Their targets cover in-range and out-of-range cores, and the two control bits are drawn independently. A behavioural model is compared with the read data and every interrupt line on every cycle.

// File: rtl/xcore_irq_pkg.sv
package xcore_irq_pkg;
    localparam int WORD_W   = 32;
    localparam int ACK_BIT  = 31;
    localparam int SEND_BIT = 30;
    localparam int PEND_BIT = 30;
    localparam int CORE_LSB = 16;
    localparam int CORE_W   = 14;
    localparam int MSG_W    = 16;

    typedef struct packed {
        logic [WORD_W-1:0] cmd;
        logic [WORD_W-1:0] mbox;
    } slot_regs_t;
endpackage

// File: rtl/xcore_irq_decode.sv
module xcore_irq_decode
    import xcore_irq_pkg::*;
#(
    parameter int NUM_CORES = 1,
    parameter int ADDR_W    = 8,
    localparam int IDX_W    = ADDR_W - 3
) (
    input  logic [ADDR_W-1:2]   addr,
    input  logic                we,
    input  logic                send_bit,
    input  logic [CORE_W-1:0]   dest,
    output logic [IDX_W-1:0]    src_idx,
    output logic                src_ok,
    output logic                sel_mbox,
    output logic [NUM_CORES-1:0] cmd_wr_vec,
    output logic [NUM_CORES-1:0] send_vec
);
    logic any_cmd_wr;

    always_comb begin
        src_idx    = addr[ADDR_W-1:3];
        sel_mbox   = addr[2];
        src_ok     = int'(src_idx) < NUM_CORES;
        any_cmd_wr = we && !sel_mbox && src_ok;
    end

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_hit
        assign cmd_wr_vec[i] = any_cmd_wr && (int'(src_idx) == i);
        assign send_vec[i]   = any_cmd_wr && send_bit && (int'(dest) == i);
    end
endmodule

// File: rtl/xcore_irq_slot.sv
module xcore_irq_slot
    import xcore_irq_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              send_hit,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  src_idx,
    output logic [WORD_W-1:0] cmd_o,
    output logic [WORD_W-1:0] mbox_o,
    output logic              irq_o
);
    slot_regs_t regs_d, regs_q;
    logic [CORE_W-1:0] src_field;

    assign src_field = CORE_W'(src_idx);

    always_comb begin
        regs_d = regs_q;
        if (cmd_wr) begin
            regs_d.cmd = wdata;
        end
        if (send_hit) begin
            regs_d.mbox = {1'b0, 1'b1, src_field, wdata[MSG_W-1:0]};
        end
        if (cmd_wr && wdata[ACK_BIT]) begin
            regs_d.mbox[PEND_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cmd_o  = regs_q.cmd;
    assign mbox_o = regs_q.mbox;
    assign irq_o  = regs_q.mbox[PEND_BIT];

    // R2
    cmd_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> cmd_o == $past(wdata));

    // R3
    send_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send_hit && !(cmd_wr && wdata[ACK_BIT]) |=>
            irq_o && mbox_o[MSG_W-1:0] == $past(wdata[MSG_W-1:0]));

    // R5
    ack_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && wdata[ACK_BIT] |=> !irq_o);

    // R4
    ack_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && wdata[ACK_BIT] && !send_hit |=>
            mbox_o[PEND_BIT-1:0] == $past(mbox_o[PEND_BIT-1:0]));

    // R6
    mbox_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !send_hit && !cmd_wr |=> $stable(mbox_o));
endmodule

// File: rtl/xcore_irq_hub.sv
module xcore_irq_hub
    import xcore_irq_pkg::*;
#(
    parameter int NUM_CORES = 1,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic [NUM_CORES-1:0] irq_o
);
    localparam int IDX_W = ADDR_W - 3;

    logic [IDX_W-1:0]     src_idx;
    logic                 src_ok;
    logic                 sel_mbox;
    logic [NUM_CORES-1:0] cmd_wr_vec;
    logic [NUM_CORES-1:0] send_vec;
    logic [WORD_W-1:0]    cmd_arr  [NUM_CORES];
    logic [WORD_W-1:0]    mbox_arr [NUM_CORES];
    logic                 unused_lsb;

    assign unused_lsb = ^bus_addr[1:0];

    xcore_irq_decode #(
        .NUM_CORES (NUM_CORES),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .addr       (bus_addr[ADDR_W-1:2]),
        .we         (bus_we),
        .send_bit   (bus_wdata[SEND_BIT]),
        .dest       (bus_wdata[CORE_LSB +: CORE_W]),
        .src_idx    (src_idx),
        .src_ok     (src_ok),
        .sel_mbox   (sel_mbox),
        .cmd_wr_vec (cmd_wr_vec),
        .send_vec   (send_vec)
    );

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_slot
        xcore_irq_slot #(
            .IDX_W (IDX_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd_wr   (cmd_wr_vec[i]),
            .send_hit (send_vec[i]),
            .wdata    (bus_wdata),
            .src_idx  (src_idx),
            .cmd_o    (cmd_arr[i]),
            .mbox_o   (mbox_arr[i]),
            .irq_o    (irq_o[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (src_ok && int'(src_idx) == i) begin
                bus_rdata = sel_mbox ? mbox_arr[i] : cmd_arr[i];
            end
        end
    end

    // R8
    oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !src_ok |-> bus_rdata == '0);

    // R6
    mbox_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr[2] |=> $stable(irq_o));
endmodule

// File: tb/xcore_irq_hub_bench.sv
module xcore_irq_hub_bench;
    localparam int N  = 4;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  irq_o;

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    bit    cyc_en = 0;
    string cur_req = "R9";

    logic [31:0] m_cmd  [N];
    logic [31:0] m_mbox [N];

    always #5 clk = ~clk;

    xcore_irq_hub #(.NUM_CORES(N), .ADDR_W(AW)) u_xcore_irq_hub (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    // Behavioural reference, updated at each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_cmd[i]  = 0;
                m_mbox[i] = 0;
            end
        end else if (bus_we) begin
            int idx, dst;
            idx = int'(bus_addr) / 8;
            if (idx < N && bus_addr[2] == 1'b0) begin
                m_cmd[idx] = bus_wdata;
                if (bus_wdata[30]) begin
                    dst = int'(bus_wdata[29:16]);
                    if (dst < N)
                        m_mbox[dst] = 32'h4000_0000 | (idx << 16) | {16'h0, bus_wdata[15:0]};
                end
                if (bus_wdata[31])
                    m_mbox[idx] = m_mbox[idx] & 32'hBFFF_FFFF;
            end
        end
    end

    function automatic logic [31:0] model_read(logic [AW-1:0] a);
        int idx;
        idx = int'(a) / 8;
        if (idx >= N) return 32'h0;
        return a[2] ? m_mbox[idx] : m_cmd[idx];
    endfunction

    function automatic logic [N-1:0] model_irq();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = m_mbox[i][30];
        return v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from the active edge (R10, R12)
    always @(posedge clk) begin
        #2;
        if (cyc_en) begin
            check({cur_req, " rdata"}, bus_rdata, model_read(bus_addr));
            check({cur_req, " irq R12"}, 32'(irq_o), 32'(model_irq()));
        end
    end

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    endtask

    task automatic rd_expect(string req, logic [AW-1:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0; bus_wdata = '0;
        @(posedge clk);
        #2;
        check(req, bus_rdata, exp);
    endtask

    task automatic irq_expect(string req, logic [N-1:0] exp);
        check(req, 32'(irq_o), 32'(exp));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cyc_en = 1;

        // R9: everything zero after reset
        for (int i = 0; i < 2 * N; i++) rd_expect("R9 reset", AW'(i * 4), 32'h0);
        irq_expect("R9 irq", '0);

        // R2: command store and readback
        cur_req = "R2";
        wr(8'h00, 32'h0000_1234);
        rd_expect("R2 readback", 8'h00, 32'h0000_1234);
        irq_expect("R2 no irq", '0);

        // R3 / R10: core 1 sends to core 2
        cur_req = "R3";
        wr(8'h08, 32'h4002_BEEF);
        rd_expect("R3 mailbox", 8'h14, 32'h4001_BEEF);
        irq_expect("R3 irq", 4'b0100);
        // R1: low address bits ignored
        rd_expect("R1 lsb ignored", 8'h17, 32'h4001_BEEF);
        rd_expect("R1 command word", 8'h09, 32'h4002_BEEF);

        // R6: mailbox write ignored
        cur_req = "R6";
        wr(8'h14, 32'h0000_0000);
        rd_expect("R6 mailbox kept", 8'h14, 32'h4001_BEEF);
        irq_expect("R6 irq kept", 4'b0100);

        // R11: newer message overwrites
        cur_req = "R11";
        wr(8'h18, 32'h4002_0055);
        rd_expect("R11 overwrite", 8'h14, 32'h4003_0055);
        irq_expect("R11 irq high", 4'b0100);

        // R4: acknowledge keeps fields
        cur_req = "R4";
        wr(8'h10, 32'h8000_0000);
        rd_expect("R4 ack", 8'h14, 32'h0003_0055);
        irq_expect("R4 irq low", 4'b0000);

        // R5: core 0 pending, then self send + ack
        cur_req = "R5";
        wr(8'h08, 32'h4000_0011);
        rd_expect("R5 setup", 8'h04, 32'h4001_0011);
        irq_expect("R5 setup irq", 4'b0001);
        wr(8'h00, 32'hC000_00AA);
        rd_expect("R5 self send ack", 8'h04, 32'h0000_00AA);
        irq_expect("R5 irq low", 4'b0000);

        // R7: out-of-range destinations
        cur_req = "R7";
        wr(8'h08, 32'h4004_0001);
        @(negedge clk); bus_we = 1'b0;
        @(posedge clk); #2;
        irq_expect("R7 dest 4", 4'b0000);
        wr(8'h08, 32'h7FFF_0001);
        rd_expect("R7 mailbox 0 kept", 8'h04, 32'h0000_00AA);
        irq_expect("R7 dest max", 4'b0000);

        // R8: out-of-range core index
        cur_req = "R8";
        wr(8'h28, 32'h4000_0001);
        rd_expect("R8 read zero", 8'h28, 32'h0);
        rd_expect("R8 mbox read zero", 8'h2C, 32'h0);
        irq_expect("R8 no irq", 4'b0000);

        // Random phase, model compared every cycle
        cur_req = "R10";
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] d;
            d = $urandom;
            d[29:16] = 14'($urandom_range(0, 5));
            @(negedge clk);
            bus_addr  = AW'($urandom_range(0, 63));
            bus_we    = ($urandom_range(0, 3) != 0);
            bus_wdata = d;
        end

        // R9: reset during activity
        cur_req = "R9";
        wr(8'h00, 32'h4001_0001);
        wr(8'h08, 32'h4000_0002);
        @(negedge clk);
        bus_we = 1'b0;
        rst_n = 1'b0;
        @(posedge clk); #2;
        irq_expect("R9 irq in reset", '0);
        @(negedge clk);
        rst_n = 1'b1;
        rd_expect("R9 mailbox cleared", 8'h0C, 32'h0);
        rd_expect("R9 command cleared", 8'h08, 32'h0);

        @(negedge clk);
        cyc_en = 0;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule